// File: doc/BRIEF.md
# Serial-Bus Wiper Controller

This block is a two-wire bus target that owns the 8-bit wiper code of a digital potentiometer. A bus master writes it with a three-byte transaction: the target address, an instruction byte carrying a midscale-reset flag and a shutdown flag, and a data byte holding the new wiper code. A read transaction returns the stored wiper code. The clock and data lines are oversampled by a faster system clock. START and STOP conditions are recognised from the synchronised line samples, and the target drives the data line only by pulling it low.

The block has three outputs. The first is the stored register value. The second is a shutdown flag, which means the wiper is shorted to the B end and the A end is disconnected. The third is the effective wiper code that the analog side should apply. That code is forced to zero while shutdown is active and is the stored value otherwise. Midscale reset overwrites the stored value itself. Shutdown leaves the stored value alone, so a code written during shutdown appears at the output as soon as shutdown is cleared.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset the stored value is 0x80, shutdown is 0, the effective code is 0x80 and SDA is not pulled.
- R2: The address byte is matched when its bits 7..2 are 010110 and its bit 1 equals `addr_sel_i`. Its bit 0 selects the direction, 1 for read and 0 for write. Any other address is not matched.
- R3: A matched address is acknowledged by pulling SDA low during the ninth clock. After an unmatched address, no byte is acknowledged and no output changes until the next START.
- R4: In a write, the instruction byte and the data byte are each acknowledged. Only instruction bit 6 (midscale) and bit 5 (shutdown) have any effect, and bits 7 and 4..0 are ignored. A byte after the data byte is not acknowledged and has no effect.
- R5: An instruction with bit 6 set loads 0x80 into the stored value, and the data byte of that same transaction leaves the stored value at 0x80.
- R6: An instruction with bit 5 set raises shutdown and drives the effective code to 0x00 while leaving the stored value unchanged. An instruction with bit 5 clear lowers shutdown and restores the effective code to the stored value.
- R7: A data byte, when midscale is not requested, becomes the stored value. The effective code follows it, except during shutdown, where it takes effect when shutdown is cleared.
- R8: In a read, the stored value is sent MSB first right after the address acknowledge. If the master acknowledges, the value is sent again. If the master does not acknowledge, the read ends.
- R9: The target changes its SDA drive only after a falling SCL edge, or on START or STOP. The acknowledge level is therefore stable while SCL is high.
- R10: A repeated START aborts the current transaction and restarts address decoding. A write whose data byte was never sent leaves the stored value unchanged.
- R11: A STOP releases SDA and returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Selects address bit 1 of the matched address byte |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wiper_o | output | 8 | Effective wiper code (0x00 during shutdown) |
| shutdown_o | output | 1 | Wiper shorted to B, A end disconnected |
| wiper_reg_o | output | 8 | Stored wiper register value |

## Verification
The hardest case to reach from the ports is a code written while shutdown is active. It must reach the stored value but not the effective code, and then reappear only when shutdown is cleared. The stimulus gets there with an instruction-only write that enters shutdown, then a full write of a new code, then a readback over the bus during shutdown. A final instruction-only write with bit 5 clear releases shutdown. A second hard case is an aborted write. A repeated START after the instruction byte turns the transaction into a read, and the data returned shows that no data byte was committed.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int WIPER_W = 8;
  localparam int MIDSCALE_BIT = 6;
  localparam int SHUTDOWN_BIT = 5;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_INSTR,
    ST_INSTR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_READ,
    ST_READ_ACK,
    ST_IGNORE
  } bus_state_t;
endpackage

// File: rtl/wiper_bus_sync.sv
module wiper_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/wiper_bus_fsm.sv
module wiper_bus_fsm
  import wiper_pkg::*;
#(
  parameter int                  DATA_W     = WIPER_W,
  parameter logic [DATA_W-3:0]   ADDR_FIXED = 6'b010110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              addr_sel,
  input  logic [DATA_W-1:0] rd_value,
  output logic              sda_drv,
  output logic              instr_we,
  output logic              instr_rs,
  output logic              instr_sd,
  output logic              data_we,
  output logic [DATA_W-1:0] data_val
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = (CNT_W)'(DATA_W - 1);

  bus_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full_q;
  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] txreg_q;
  logic              rw_q;
  logic              nack_q;
  logic              addr_hit;

  assign addr_hit = (shreg_q[DATA_W-1:1] == {ADDR_FIXED, addr_sel});

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      full_q   <= 1'b0;
      shreg_q  <= '0;
      txreg_q  <= '0;
      rw_q     <= 1'b0;
      nack_q   <= 1'b0;
      sda_drv  <= 1'b0;
      instr_we <= 1'b0;
      instr_rs <= 1'b0;
      instr_sd <= 1'b0;
      data_we  <= 1'b0;
      data_val <= '0;
    end else begin
      instr_we <= 1'b0;
      data_we  <= 1'b0;
      if (start_det) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        full_q  <= 1'b0;
        sda_drv <= 1'b0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        full_q  <= 1'b0;
        sda_drv <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_INSTR, ST_DATA: begin
            if (scl_rise && !full_q) begin
              shreg_q <= {shreg_q[DATA_W-2:0], sda_s};
              if (cnt_q == LAST_BIT) full_q <= 1'b1;
              else                   cnt_q  <= cnt_q + 1'b1;
            end else if (scl_fall && full_q) begin
              full_q <= 1'b0;
              cnt_q  <= '0;
              case (state_q)
                ST_ADDR: begin
                  if (addr_hit) begin
                    rw_q    <= shreg_q[0];
                    sda_drv <= 1'b1;
                    state_q <= ST_ADDR_ACK;
                  end else begin
                    state_q <= ST_IGNORE;
                  end
                end
                ST_INSTR: begin
                  instr_we <= 1'b1;
                  instr_rs <= shreg_q[MIDSCALE_BIT];
                  instr_sd <= shreg_q[SHUTDOWN_BIT];
                  sda_drv  <= 1'b1;
                  state_q  <= ST_INSTR_ACK;
                end
                default: begin
                  data_we  <= 1'b1;
                  data_val <= shreg_q;
                  sda_drv  <= 1'b1;
                  state_q  <= ST_DATA_ACK;
                end
              endcase
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                txreg_q <= rd_value;
                sda_drv <= ~rd_value[DATA_W-1];
                cnt_q   <= '0;
                state_q <= ST_READ;
              end else begin
                sda_drv <= 1'b0;
                state_q <= ST_INSTR;
              end
            end
          end
          ST_INSTR_ACK: begin
            if (scl_fall) begin
              sda_drv <= 1'b0;
              state_q <= ST_DATA;
            end
          end
          ST_DATA_ACK: begin
            if (scl_fall) begin
              sda_drv <= 1'b0;
              state_q <= ST_IGNORE;
            end
          end
          ST_READ: begin
            if (scl_fall) begin
              if (cnt_q == LAST_BIT) begin
                sda_drv <= 1'b0;
                cnt_q   <= '0;
                state_q <= ST_READ_ACK;
              end else begin
                sda_drv <= ~txreg_q[DATA_W-2];
                txreg_q <= {txreg_q[DATA_W-2:0], 1'b0};
                cnt_q   <= cnt_q + 1'b1;
              end
            end
          end
          ST_READ_ACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (nack_q) begin
                state_q <= ST_IGNORE;
              end else begin
                txreg_q <= rd_value;
                sda_drv <= ~rd_value[DATA_W-1];
                cnt_q   <= '0;
                state_q <= ST_READ;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: the drive level only moves on a falling SCL edge or a bus condition
  assert_drive_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_drv) |-> $past(scl_fall || start_det || stop_det));

  assert_restart_decode_R10: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state_q == ST_ADDR && cnt_q == '0 && !full_q));

  assert_stop_release_R11: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_drv && state_q == ST_IDLE));

  // R3: an unmatched address never leads to a strobe into the register file
  assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IGNORE) |-> (!instr_we && !data_we));
endmodule

// File: rtl/wiper_regs.sv
module wiper_regs #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] MIDSCALE = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_we,
  input  logic              instr_rs,
  input  logic              instr_sd,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_val,
  output logic [DATA_W-1:0] reg_q,
  output logic              sd_q,
  output logic [DATA_W-1:0] wiper_q
);
  logic              hold_q;
  logic [DATA_W-1:0] reg_n;
  logic              sd_n;
  logic              hold_n;

  always_comb begin
    reg_n  = reg_q;
    sd_n   = sd_q;
    hold_n = hold_q;
    if (instr_we) begin
      sd_n   = instr_sd;
      hold_n = instr_rs;
      if (instr_rs) reg_n = MIDSCALE;
    end
    if (data_we && !hold_q) reg_n = data_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q   <= MIDSCALE;
      sd_q    <= 1'b0;
      hold_q  <= 1'b0;
      wiper_q <= MIDSCALE;
    end else begin
      reg_q   <= reg_n;
      sd_q    <= sd_n;
      hold_q  <= hold_n;
      wiper_q <= sd_n ? '0 : reg_n;
    end
  end

  assert_midscale_load_R5: assert property (@(posedge clk) disable iff (rst)
    (instr_we && instr_rs) |=> (reg_q == MIDSCALE));

  assert_shutdown_keeps_reg_R6: assert property (@(posedge clk) disable iff (rst)
    (instr_we && instr_sd && !instr_rs && !data_we) |=> (reg_q == $past(reg_q)));

  assert_data_commit_R7: assert property (@(posedge clk) disable iff (rst)
    (data_we && !hold_q) |=> (reg_q == $past(data_val)));

  assert_shutdown_output_R6: assert property (@(posedge clk) disable iff (rst)
    (instr_we && instr_sd) |=> (sd_q && wiper_q == '0));
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave
  import wiper_pkg::*;
#(
  parameter int                     SYNC_STAGES = 2,
  parameter int                     DATA_W      = WIPER_W,
  parameter logic [DATA_W-3:0]      ADDR_FIXED  = 6'b010110,
  parameter logic [DATA_W-1:0]      MIDSCALE    = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_pull_o,
  output logic [DATA_W-1:0] wiper_o,
  output logic              shutdown_o,
  output logic [DATA_W-1:0] wiper_reg_o
);
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              instr_we;
  logic              instr_rs;
  logic              instr_sd;
  logic              data_we;
  logic [DATA_W-1:0] data_val;
  logic [DATA_W-1:0] reg_value;

  wiper_bus_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  wiper_bus_fsm #(
    .DATA_W    (DATA_W),
    .ADDR_FIXED(ADDR_FIXED)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .addr_sel (addr_sel_i),
    .rd_value (reg_value),
    .sda_drv  (sda_pull_o),
    .instr_we (instr_we),
    .instr_rs (instr_rs),
    .instr_sd (instr_sd),
    .data_we  (data_we),
    .data_val (data_val)
  );

  wiper_regs #(
    .DATA_W  (DATA_W),
    .MIDSCALE(MIDSCALE)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .instr_we(instr_we),
    .instr_rs(instr_rs),
    .instr_sd(instr_sd),
    .data_we (data_we),
    .data_val(data_val),
    .reg_q   (reg_value),
    .sd_q    (shutdown_o),
    .wiper_q (wiper_o)
  );

  assign wiper_reg_o = reg_value;
endmodule

// File: tb/wiper_i2c_slave_bench.sv
module wiper_i2c_slave_bench;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       addr_sel = 1'b0;
  logic       sda_pull;
  logic [7:0] wiper;
  logic       shutdown;
  logic [7:0] wreg;
  wire        sda_bus = m_sda & ~sda_pull;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  wiper_i2c_slave u_wiper_i2c_slave (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (m_scl),
    .sda_i      (sda_bus),
    .addr_sel_i (addr_sel),
    .sda_pull_o (sda_pull),
    .wiper_o    (wiper),
    .shutdown_o (shutdown),
    .wiper_reg_o(wreg)
  );

  task automatic wq;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq;
    m_scl = 1'b1; wq;
    m_sda = 1'b0; wq;
    m_scl = 1'b0; wq;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq;
    m_scl = 1'b1; wq;
    m_sda = 1'b1; wq;
    wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic a0, a1;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq;
      m_scl = 1'b1; wq; wq;
      m_scl = 1'b0; wq;
    end
    m_sda = 1'b1; wq;
    m_scl = 1'b1; wq;
    a0 = ~sda_bus; wq;
    a1 = ~sda_bus;
    m_scl = 1'b0; wq;
    acked = a0;
    chk("R9 ack level steady while SCL high", int'(a1), int'(a0));
  endtask

  task automatic read_byte(input logic master_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq;
      m_scl = 1'b1; wq;
      b[i] = sda_bus; wq;
      m_scl = 1'b0;
    end
    wq;
    m_sda = master_ack ? 1'b0 : 1'b1; wq;
    m_scl = 1'b1; wq; wq;
    m_scl = 1'b0; wq;
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] addr_byte(input logic sel, input logic rd);
    return {6'b010110, sel, rd};
  endfunction

  task automatic write_txn(input logic [7:0] instr, input logic [7:0] data, input string tag);
    logic ack;
    bus_start;
    send_byte(addr_byte(addr_sel, 1'b0), ack);
    chk({tag, " address ack"}, int'(ack), 1);
    send_byte(instr, ack);
    chk({tag, " instruction ack"}, int'(ack), 1);
    send_byte(data, ack);
    chk({tag, " data ack"}, int'(ack), 1);
    bus_stop;
  endtask

  task automatic instr_only_txn(input logic [7:0] instr, input string tag);
    logic ack;
    bus_start;
    send_byte(addr_byte(addr_sel, 1'b0), ack);
    chk({tag, " address ack"}, int'(ack), 1);
    send_byte(instr, ack);
    chk({tag, " instruction ack"}, int'(ack), 1);
    bus_stop;
  endtask

  task automatic t_reset;
    chk("R1 stored value after reset", int'(wreg), 'h80);
    chk("R1 effective code after reset", int'(wiper), 'h80);
    chk("R1 shutdown after reset", int'(shutdown), 0);
    chk("R1 SDA released after reset", int'(sda_pull), 0);
  endtask

  task automatic t_basic_write;
    write_txn(8'h00, 8'h3C, "R4 basic write");
    chk("R7 stored value after write", int'(wreg), 'h3C);
    chk("R7 effective code after write", int'(wiper), 'h3C);
  endtask

  task automatic t_wrong_address;
    logic ack;
    bus_start;
    send_byte(addr_byte(1'b1, 1'b0), ack);
    chk("R2 pin bit mismatch not acked", int'(ack), 0);
    send_byte(8'h40, ack);
    chk("R3 byte after mismatch not acked", int'(ack), 0);
    send_byte(8'h00, ack);
    chk("R3 second byte after mismatch not acked", int'(ack), 0);
    bus_stop;
    chk("R3 value untouched by foreign write", int'(wreg), 'h3C);
    chk("R3 effective code untouched", int'(wiper), 'h3C);
    bus_start;
    send_byte({6'b010111, 1'b0, 1'b0}, ack);
    chk("R2 fixed bits mismatch not acked", int'(ack), 0);
    bus_stop;
  endtask

  task automatic t_pin_select;
    logic ack;
    addr_sel = 1'b1; wq;
    write_txn(8'h00, 8'h11, "R2 pin high");
    chk("R2 write via pin-selected address", int'(wreg), 'h11);
    bus_start;
    send_byte(addr_byte(1'b0, 1'b0), ack);
    chk("R2 old address rejected with pin high", int'(ack), 0);
    bus_stop;
    addr_sel = 1'b0; wq;
  endtask

  task automatic t_read;
    logic ack;
    logic [7:0] b;
    bus_start;
    send_byte(addr_byte(1'b0, 1'b1), ack);
    chk("R8 read address ack", int'(ack), 1);
    read_byte(1'b1, b);
    chk("R8 first read byte", int'(b), 'h11);
    read_byte(1'b0, b);
    chk("R8 repeated read byte after master ack", int'(b), 'h11);
    chk("R8 SDA released after master nack", int'(sda_pull), 0);
    bus_stop;
    chk("R11 SDA released after stop", int'(sda_pull), 0);
    chk("R8 read leaves value", int'(wreg), 'h11);
  endtask

  task automatic t_extra_byte;
    logic ack;
    bus_start;
    send_byte(addr_byte(1'b0, 1'b0), ack);
    send_byte(8'h00, ack);
    send_byte(8'h5A, ack);
    chk("R4 data ack before extra byte", int'(ack), 1);
    send_byte(8'h99, ack);
    chk("R4 extra byte not acked", int'(ack), 0);
    bus_stop;
    chk("R4 extra byte ignored", int'(wreg), 'h5A);
  endtask

  task automatic t_ignored_bits;
    write_txn(8'h9F, 8'h21, "R4 ignored instruction bits");
    chk("R4 bits 7,4..0 have no effect on value", int'(wreg), 'h21);
    chk("R4 bits 7,4..0 have no effect on shutdown", int'(shutdown), 0);
    chk("R4 effective code follows", int'(wiper), 'h21);
  endtask

  task automatic t_midscale;
    write_txn(8'h40, 8'hAA, "R5 midscale");
    chk("R5 stored value forced to midscale", int'(wreg), 'h80);
    chk("R5 effective code at midscale", int'(wiper), 'h80);
    write_txn(8'h00, 8'h33, "R5 exit midscale");
    chk("R5 later write lands normally", int'(wreg), 'h33);
  endtask

  task automatic t_shutdown;
    logic ack;
    logic [7:0] b;
    write_txn(8'h00, 8'h77, "R6 preload");
    instr_only_txn(8'h20, "R6 enter");
    chk("R6 shutdown raised", int'(shutdown), 1);
    chk("R6 effective code zero", int'(wiper), 0);
    chk("R6 stored value unchanged", int'(wreg), 'h77);
    write_txn(8'h20, 8'h55, "R7 write in shutdown");
    chk("R7 stored value written in shutdown", int'(wreg), 'h55);
    chk("R7 effective code still zero", int'(wiper), 0);
    bus_start;
    send_byte(addr_byte(1'b0, 1'b1), ack);
    read_byte(1'b0, b);
    bus_stop;
    chk("R8 readback during shutdown", int'(b), 'h55);
    instr_only_txn(8'h00, "R6 leave");
    chk("R6 shutdown cleared", int'(shutdown), 0);
    chk("R7 new value applied after shutdown", int'(wiper), 'h55);
  endtask

  task automatic t_restart;
    logic ack;
    logic [7:0] b;
    bus_start;
    send_byte(addr_byte(1'b0, 1'b0), ack);
    send_byte(8'h00, ack);
    bus_start;
    send_byte(addr_byte(1'b0, 1'b1), ack);
    chk("R10 address acked after repeated start", int'(ack), 1);
    read_byte(1'b0, b);
    bus_stop;
    chk("R10 read after repeated start", int'(b), 'h55);
    chk("R10 aborted write left value", int'(wreg), 'h55);
    bus_start;
    send_byte({6'b010110, 1'b0, 1'b0}, ack);
    send_byte(8'h00, ack);
    bus_start;
    send_byte(addr_byte(1'b0, 1'b0), ack);
    send_byte(8'h00, ack);
    send_byte(8'h66, ack);
    bus_stop;
    chk("R10 write completes after restart", int'(wreg), 'h66);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (10) @(posedge clk);
    #1 rst = 1'b0;
    wq;
    t_reset;
    t_basic_write;
    t_wrong_address;
    t_pin_select;
    t_read;
    t_extra_byte;
    t_ignored_bits;
    t_midscale;
    t_shutdown;
    t_restart;
    finish_run;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule